// File: doc/BRIEF.md
# Boot Gatekeeper Sequencer

This block supervises the start-up of an external processor that cannot verify its own boot code. From power-on reset it keeps the processor in reset and starts a local self-test. Only after the self-test reports success does it release the processor's reset. At that point it also captures a random nonce from a random-source input. The processor then reads its boot image through an SPI slave port. The block fetches image bytes from a memory port and replaces a fixed window of addresses with the captured nonce.

The processor hashes what it received and writes the digest back over the same SPI port. The block compares that digest with an expected value on an input port. That value is computed outside the block from the image and the exported nonce. A match moves the block to a trusted state that lets the boot continue. Any of the following moves it to a locked abort state, in which the processor is held in reset until the next power-on reset:
- a digest mismatch,
- a missing digest (timeout),
- a failed self-test,
- a tamper alarm.

Top module: `boot_gate_seq`

## Requirements
- R1: `tgt_rst_n` is low from reset and stays low while `selftest_go` is high. It first goes high in the cycle after `selftest_done` and `selftest_pass` are both seen high.
- R2: A `selftest_done` pulse with `selftest_pass` low makes `boot_abort` go high, and `tgt_rst_n` stays low.
- R3: SPI uses mode 0 (sample on rising SCLK, shift on falling SCLK), MSB first, framed by `spi_cs_n` low. Command byte 0x03 is followed by a high address byte and a low address byte. Every later byte slot returns the image byte at the current address, and the address then increments by one.
- R4: For byte addresses NONCE_ADDR to NONCE_ADDR+NONCE_BYTES-1, the served byte is taken from the nonce instead of the memory, with offset 0 carrying the most significant nonce byte. The nonce is `rng_value` captured in the cycle the self-test pass is taken. It is driven on `nonce_out` and stays unchanged until the next reset, however many times the image is re-read.
- R5: `spi_miso` is 0 in every state other than image serving, and also during any transaction whose command byte is neither 0x03 nor 0x02.
- R6: While serving, command byte 0x02 ends serving and starts digest collection. The next DIG_BYTES bytes form the digest, most significant byte first. If it equals `exp_digest`, `boot_ok` goes high and `tgt_rst_n` stays high.
- R7: If the collected digest differs from `exp_digest`, `boot_abort` goes high and `tgt_rst_n` goes low.
- R8: If a complete digest has not arrived TIMEOUT clock cycles after digest collection starts, `boot_abort` goes high.
- R9: `tamper` high in any state makes `boot_abort` high in the next cycle, including after `boot_ok`.
- R10: Once `boot_abort` is high, it stays high and `tgt_rst_n` and `boot_ok` stay low until `rst_n` is asserted, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| selftest_go | output | 1 | High while the self-test is requested |
| selftest_done | input | 1 | Self-test finished (one-cycle pulse) |
| selftest_pass | input | 1 | Self-test result, valid with `selftest_done` |
| tamper | input | 1 | Environmental tamper alarm |
| tgt_rst_n | output | 1 | Reset to the target processor, active low |
| spi_sclk | input | 1 | SPI clock from the target |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | SPI data from the target |
| spi_miso | output | 1 | SPI data to the target |
| img_addr | output | 16 | Byte address to the boot image memory |
| img_data | input | 8 | Image byte at `img_addr` (combinational read) |
| rng_value | input | NONCE_BYTES*8 | Random source value |
| nonce_out | output | NONCE_BYTES*8 | Nonce captured for this boot |
| exp_digest | input | DIG_BYTES*8 | Expected digest for the served image and nonce |
| boot_ok | output | 1 | Digest matched; boot may continue |
| boot_abort | output | 1 | Boot terminated and locked |

## Verification
The assertions assume that `selftest_done` is a single-cycle pulse and that `selftest_pass` is valid in that cycle. They also assume that the SPI signals change slowly compared with `clk`: at least several clock cycles pass between SCLK edges, so the synchronised edge detector sees every edge. The stimulus drives SCLK with a half period of eight clocks and holds MOSI and chip select steady around each edge. It changes `rng_value` only after the nonce has been captured, so any later change must not reach `nonce_out`. `exp_digest` is held constant across each digest comparison.

// File: rtl/boot_gate_pkg.sv
package boot_gate_pkg;

    typedef enum logic [2:0] {
        ST_RESET_HOLD,
        ST_SELFTEST,
        ST_SERVE,
        ST_AWAIT_DIGEST,
        ST_COMPARE,
        ST_TRUSTED,
        ST_ABORT
    } gate_state_e;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADDR_HI,
        PH_ADDR_LO,
        PH_READ,
        PH_DIGEST,
        PH_SKIP
    } spi_phase_e;

    localparam logic [7:0] CMD_READ   = 8'h03;
    localparam logic [7:0] CMD_DIGEST = 8'h02;

endpackage

// File: rtl/boot_gate_spi.sv
module boot_gate_spi
    import boot_gate_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sclk,
    input  logic        cs_n,
    input  logic        mosi,
    input  logic        serve_en,
    output logic [15:0] rd_addr,
    input  logic [7:0]  rd_byte,
    output logic        miso,
    output logic        dig_start,
    output logic        rx_vld,
    output logic [7:0]  rx_byte
);

    typedef struct packed {
        logic [2:0]  sclk_s;
        logic [1:0]  cs_s;
        logic [1:0]  mosi_s;
        logic [2:0]  bit_cnt;
        logic [7:0]  shift;
        spi_phase_e  phase;
        logic [7:0]  addr_hi;
        logic [15:0] addr;
        logic [7:0]  tx;
    } spi_regs_t;

    spi_regs_t q, d;
    logic      rise, fall;
    logic [7:0] byte_in;

    always_comb begin
        d         = q;
        dig_start = 1'b0;
        rx_vld    = 1'b0;
        rx_byte   = 8'h00;
        d.sclk_s  = {q.sclk_s[1:0], sclk};
        d.cs_s    = {q.cs_s[0], cs_n};
        d.mosi_s  = {q.mosi_s[0], mosi};
        rise      = q.sclk_s[1] & ~q.sclk_s[2];
        fall      = ~q.sclk_s[1] & q.sclk_s[2];
        byte_in   = {q.shift[6:0], q.mosi_s[1]};

        if (q.cs_s[1]) begin
            d.bit_cnt = '0;
            d.phase   = PH_CMD;
            d.tx      = 8'h00;
        end else if (rise) begin
            d.shift   = byte_in;
            d.bit_cnt = q.bit_cnt + 3'd1;
            if (q.bit_cnt == 3'd7) begin
                unique case (q.phase)
                    PH_CMD: begin
                        if (byte_in == CMD_READ) begin
                            d.phase = PH_ADDR_HI;
                        end else if (byte_in == CMD_DIGEST) begin
                            d.phase   = PH_DIGEST;
                            dig_start = 1'b1;
                        end else begin
                            d.phase = PH_SKIP;
                        end
                    end
                    PH_ADDR_HI: begin
                        d.addr_hi = byte_in;
                        d.phase   = PH_ADDR_LO;
                    end
                    PH_ADDR_LO: begin
                        d.addr  = {q.addr_hi, byte_in};
                        d.phase = PH_READ;
                    end
                    PH_READ:   d.addr = q.addr + 16'd1;
                    PH_DIGEST: begin
                        rx_vld  = 1'b1;
                        rx_byte = byte_in;
                    end
                    default: ;
                endcase
            end
        end else if (fall) begin
            if (q.bit_cnt == 3'd0) begin
                d.tx = (q.phase == PH_READ) ? rd_byte : 8'h00;
            end else begin
                d.tx = {q.tx[6:0], 1'b0};
            end
        end

        rd_addr = q.addr;
        miso    = serve_en & q.tx[7];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.cs_s    <= 2'b11;
            q.phase   <= PH_CMD;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/boot_gate_imgmux.sv
module boot_gate_imgmux #(
    parameter int          NONCE_BYTES = 2,
    parameter logic [15:0] NONCE_ADDR  = 16'h0010,
    localparam int         NONCE_W     = NONCE_BYTES * 8
) (
    input  logic [15:0]        rd_addr,
    input  logic [7:0]         img_data,
    input  logic [NONCE_W-1:0] nonce,
    output logic [7:0]         rd_byte
);

    logic [16:0] offset;

    always_comb begin
        offset  = {1'b0, rd_addr} - {1'b0, NONCE_ADDR};
        rd_byte = img_data;
        for (int i = 0; i < NONCE_BYTES; i++) begin
            if (rd_addr >= NONCE_ADDR && offset == 17'(i)) begin
                rd_byte = nonce[(NONCE_BYTES-1-i)*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/boot_gate_fsm.sv
module boot_gate_fsm
    import boot_gate_pkg::*;
#(
    parameter int  NONCE_BYTES = 2,
    parameter int  DIG_BYTES   = 4,
    parameter int  TIMEOUT     = 4000,
    localparam int NONCE_W     = NONCE_BYTES * 8,
    localparam int DIG_W       = DIG_BYTES * 8,
    localparam int TMO_W       = $clog2(TIMEOUT + 1),
    localparam int CNT_W       = $clog2(DIG_BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               selftest_done,
    input  logic               selftest_pass,
    input  logic               tamper,
    input  logic               dig_start,
    input  logic               rx_vld,
    input  logic [7:0]         rx_byte,
    input  logic [NONCE_W-1:0] rng_value,
    input  logic [DIG_W-1:0]   exp_digest,
    output logic [NONCE_W-1:0] nonce,
    output logic               serve_en,
    output logic               selftest_go,
    output logic               tgt_rst_n,
    output logic               boot_ok,
    output logic               boot_abort
);

    typedef struct packed {
        gate_state_e        state;
        logic [NONCE_W-1:0] nonce;
        logic [DIG_W-1:0]   dig;
        logic [CNT_W-1:0]   dig_cnt;
        logic [TMO_W-1:0]   tmo;
    } fsm_regs_t;

    fsm_regs_t q, d;

    always_comb begin
        d = q;
        unique case (q.state)
            ST_RESET_HOLD: d.state = ST_SELFTEST;
            ST_SELFTEST: begin
                if (selftest_done) begin
                    if (selftest_pass) begin
                        d.state = ST_SERVE;
                        d.nonce = rng_value;
                    end else begin
                        d.state = ST_ABORT;
                    end
                end
            end
            ST_SERVE: begin
                if (dig_start) begin
                    d.state   = ST_AWAIT_DIGEST;
                    d.dig_cnt = '0;
                    d.tmo     = '0;
                end
            end
            ST_AWAIT_DIGEST: begin
                d.tmo = q.tmo + 1'b1;
                if (dig_start) begin
                    d.dig_cnt = '0;
                end else if (rx_vld) begin
                    d.dig     = {q.dig[DIG_W-9:0], rx_byte};
                    d.dig_cnt = q.dig_cnt + 1'b1;
                    if (q.dig_cnt == CNT_W'(DIG_BYTES - 1)) begin
                        d.state = ST_COMPARE;
                    end
                end
                if (q.tmo == TMO_W'(TIMEOUT - 1) && d.state != ST_COMPARE) begin
                    d.state = ST_ABORT;
                end
            end
            ST_COMPARE: d.state = (q.dig == exp_digest) ? ST_TRUSTED : ST_ABORT;
            ST_TRUSTED: ;
            default:    d.state = ST_ABORT;
        endcase
        if (tamper) begin
            d.state = ST_ABORT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_RESET_HOLD;
        end else begin
            q <= d;
        end
    end

    assign nonce       = q.nonce;
    assign serve_en    = (q.state == ST_SERVE);
    assign selftest_go = (q.state == ST_SELFTEST);
    assign tgt_rst_n   = (q.state == ST_SERVE) || (q.state == ST_AWAIT_DIGEST) ||
                         (q.state == ST_COMPARE) || (q.state == ST_TRUSTED);
    assign boot_ok     = (q.state == ST_TRUSTED);
    assign boot_abort  = (q.state == ST_ABORT);

endmodule

// File: rtl/boot_gate_seq.sv
module boot_gate_seq
    import boot_gate_pkg::*;
#(
    parameter int          NONCE_BYTES = 2,
    parameter int          DIG_BYTES   = 4,
    parameter int          TIMEOUT     = 4000,
    parameter logic [15:0] NONCE_ADDR  = 16'h0010,
    localparam int         NONCE_W     = NONCE_BYTES * 8,
    localparam int         DIG_W       = DIG_BYTES * 8
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic               selftest_go,
    input  logic               selftest_done,
    input  logic               selftest_pass,
    input  logic               tamper,
    output logic               tgt_rst_n,
    input  logic               spi_sclk,
    input  logic               spi_cs_n,
    input  logic               spi_mosi,
    output logic               spi_miso,
    output logic [15:0]        img_addr,
    input  logic [7:0]         img_data,
    input  logic [NONCE_W-1:0] rng_value,
    output logic [NONCE_W-1:0] nonce_out,
    input  logic [DIG_W-1:0]   exp_digest,
    output logic               boot_ok,
    output logic               boot_abort
);

    logic        serve_en;
    logic        dig_start;
    logic        rx_vld;
    logic [7:0]  rx_byte;
    logic [15:0] rd_addr;
    logic [7:0]  rd_byte;

    boot_gate_spi spi_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (spi_sclk),
        .cs_n      (spi_cs_n),
        .mosi      (spi_mosi),
        .serve_en  (serve_en),
        .rd_addr   (rd_addr),
        .rd_byte   (rd_byte),
        .miso      (spi_miso),
        .dig_start (dig_start),
        .rx_vld    (rx_vld),
        .rx_byte   (rx_byte)
    );

    boot_gate_imgmux #(
        .NONCE_BYTES (NONCE_BYTES),
        .NONCE_ADDR  (NONCE_ADDR)
    ) mux_i (
        .rd_addr  (rd_addr),
        .img_data (img_data),
        .nonce    (nonce_out),
        .rd_byte  (rd_byte)
    );

    boot_gate_fsm #(
        .NONCE_BYTES (NONCE_BYTES),
        .DIG_BYTES   (DIG_BYTES),
        .TIMEOUT     (TIMEOUT)
    ) fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .selftest_done (selftest_done),
        .selftest_pass (selftest_pass),
        .tamper        (tamper),
        .dig_start     (dig_start),
        .rx_vld        (rx_vld),
        .rx_byte       (rx_byte),
        .rng_value     (rng_value),
        .exp_digest    (exp_digest),
        .nonce         (nonce_out),
        .serve_en      (serve_en),
        .selftest_go   (selftest_go),
        .tgt_rst_n     (tgt_rst_n),
        .boot_ok       (boot_ok),
        .boot_abort    (boot_abort)
    );

    assign img_addr = rd_addr;

endmodule

// File: rtl/boot_gate_chk.sv
module boot_gate_chk #(
    parameter int NONCE_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               selftest_go,
    input logic               selftest_done,
    input logic               selftest_pass,
    input logic               tamper,
    input logic               tgt_rst_n,
    input logic               spi_miso,
    input logic [NONCE_W-1:0] nonce_out,
    input logic               boot_ok,
    input logic               boot_abort
);

    p_release_after_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tgt_rst_n) |-> $past(selftest_done && selftest_pass));

    p_hold_in_selftest_r1: assert property (@(posedge clk) disable iff (!rst_n)
        selftest_go |-> !tgt_rst_n);

    p_fail_aborts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (selftest_go && selftest_done && !selftest_pass) |=> boot_abort);

    p_nonce_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_rst_n && $past(tgt_rst_n)) |-> $stable(nonce_out));

    p_miso_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_rst_n |-> !spi_miso);

    p_tamper_aborts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tamper |=> boot_abort);

    p_abort_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        boot_abort |=> boot_abort);

    p_abort_locks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        boot_abort |-> (!tgt_rst_n && !boot_ok));

    p_ok_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_ok && !tamper) |=> (boot_ok && tgt_rst_n));

endmodule

bind boot_gate_seq boot_gate_chk #(
    .NONCE_W (NONCE_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .selftest_go   (selftest_go),
    .selftest_done (selftest_done),
    .selftest_pass (selftest_pass),
    .tamper        (tamper),
    .tgt_rst_n     (tgt_rst_n),
    .spi_miso      (spi_miso),
    .nonce_out     (nonce_out),
    .boot_ok       (boot_ok),
    .boot_abort    (boot_abort)
);

// File: tb/boot_gate_seq_tb_top.sv
module boot_gate_seq_tb_top;

    localparam int          NB   = 2;
    localparam int          DB   = 4;
    localparam int          TMO  = 600;
    localparam logic [15:0] NADR = 16'h0010;
    localparam int          HALF = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            selftest_go, selftest_done = 1'b0, selftest_pass = 1'b0;
    logic            tamper = 1'b0;
    logic            tgt_rst_n;
    logic            spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0, spi_miso;
    logic [15:0]     img_addr;
    logic [7:0]      img_data;
    logic [NB*8-1:0] rng_value = '0, nonce_out;
    logic [DB*8-1:0] exp_digest = '0;
    logic            boot_ok, boot_abort;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [7:0]      exp_q[$];
    int              req_q[$];
    logic [7:0]      cap_byte;
    event            cap_ev;
    logic [NB*8-1:0] exp_nonce;

    always #5 clk = ~clk;

    assign img_data = img_addr[7:0] ^ img_addr[15:8] ^ 8'hA5;

    boot_gate_seq #(
        .NONCE_BYTES (NB),
        .DIG_BYTES   (DB),
        .TIMEOUT     (TMO),
        .NONCE_ADDR  (NADR)
    ) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .selftest_go   (selftest_go),
        .selftest_done (selftest_done),
        .selftest_pass (selftest_pass),
        .tamper        (tamper),
        .tgt_rst_n     (tgt_rst_n),
        .spi_sclk      (spi_sclk),
        .spi_cs_n      (spi_cs_n),
        .spi_mosi      (spi_mosi),
        .spi_miso      (spi_miso),
        .img_addr      (img_addr),
        .img_data      (img_data),
        .rng_value     (rng_value),
        .nonce_out     (nonce_out),
        .exp_digest    (exp_digest),
        .boot_ok       (boot_ok),
        .boot_abort    (boot_abort)
    );

    task automatic chk(input int req, input logic [31:0] got, input logic [31:0] exp, input string what);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] model_byte(input logic [15:0] a);
        logic [16:0] off;
        off = {1'b0, a} - {1'b0, NADR};
        if (a >= NADR && off < 17'(NB)) return exp_nonce[(NB-1-int'(off))*8 +: 8];
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            spi_mosi = tx[i];
            wait_clk(HALF);
            spi_sclk = 1'b1;
            rx[i] = spi_miso;
            wait_clk(HALF);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic cs_begin();
        @(negedge clk);
        spi_cs_n = 1'b0;
        wait_clk(4);
    endtask

    task automatic cs_end();
        wait_clk(4);
        spi_cs_n = 1'b1;
        wait_clk(8);
    endtask

    // Driver: pushes expected read bytes, then clocks the transaction.
    task automatic spi_read(input int req, input logic [15:0] a, input int n, input bit serving);
        logic [7:0] rx;
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(serving ? model_byte(a + 16'(i)) : 8'h00);
            req_q.push_back(req);
        end
        cs_begin();
        spi_byte(8'h03, rx);
        spi_byte(a[15:8], rx);
        spi_byte(a[7:0], rx);
        for (int i = 0; i < n; i++) begin
            spi_byte(8'h00, rx);
            cap_byte = rx;
            ->cap_ev;
        end
        cs_end();
    endtask

    task automatic spi_other(input int req, input logic [7:0] cmd, input int n);
        logic [7:0] rx;
        cs_begin();
        spi_byte(cmd, rx);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(8'h00);
            req_q.push_back(req);
            spi_byte(8'h3C, rx);
            cap_byte = rx;
            ->cap_ev;
        end
        cs_end();
    endtask

    task automatic spi_digest(input logic [31:0] dg, input int n);
        logic [7:0] rx;
        cs_begin();
        spi_byte(8'h02, rx);
        for (int i = 0; i < n; i++) spi_byte(dg[(DB-1-i)*8 +: 8], rx);
        cs_end();
    endtask

    task automatic power_up();
        @(negedge clk);
        rst_n = 1'b0;
        tamper = 1'b0;
        selftest_done = 1'b0;
        selftest_pass = 1'b0;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
    endtask

    task automatic selftest(input bit pass_v);
        @(negedge clk);
        selftest_done = 1'b1;
        selftest_pass = pass_v;
        @(negedge clk);
        selftest_done = 1'b0;
        selftest_pass = 1'b0;
        wait_clk(2);
    endtask

    // Monitor: pops the scoreboard for every captured byte.
    initial begin
        forever begin
            @(cap_ev);
            if (exp_q.size() == 0) begin
                chk(0, {24'h0, cap_byte}, 32'hFFFF_FFFF, "unexpected SPI byte");
            end else begin
                chk(req_q.pop_front(), {24'h0, cap_byte}, {24'h0, exp_q.pop_front()}, "SPI read byte");
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // Boot 1: pass self-test, good digest, then tamper.
        power_up();
        chk(1, {31'h0, tgt_rst_n}, 32'h0, "R1 target reset held after reset");
        chk(1, {31'h0, selftest_go}, 32'h1, "R1 self-test requested");
        chk(6, {30'h0, boot_ok, boot_abort}, 32'h0, "R6 no verdict at start");
        spi_read(5, 16'h0000, 2, 1'b0);                   // R5: silent before serving
        chk(1, {31'h0, tgt_rst_n}, 32'h0, "R1 still held before self-test result");
        rng_value = 16'hBEEF;
        exp_nonce = 16'hBEEF;
        selftest(1'b1);
        rng_value = 16'h1234;
        chk(1, {31'h0, tgt_rst_n}, 32'h1, "R1 target reset released");
        chk(4, {16'h0, nonce_out}, 32'h0000BEEF, "R4 nonce captured");
        spi_read(3, 16'h000E, 6, 1'b1);                   // R3 and R4: straddles nonce window
        spi_read(4, NADR, 2, 1'b1);                        // R4: re-read gives same nonce
        spi_read(3, 16'h12FF, 3, 1'b1);                    // R3: address carry into high byte
        spi_other(5, 8'h7E, 2);                            // R5: unknown command is silent
        chk(4, {16'h0, nonce_out}, 32'h0000BEEF, "R4 nonce unchanged by rng");
        exp_digest = 32'hCAFEF00D;
        spi_digest(32'hCAFEF00D, DB);
        wait_clk(4);
        chk(6, {30'h0, boot_ok, boot_abort}, 32'h2, "R6 digest match trusted");
        chk(6, {31'h0, tgt_rst_n}, 32'h1, "R6 target keeps running");
        spi_read(5, NADR, 2, 1'b0);                        // R5: silent once trusted
        @(negedge clk);
        tamper = 1'b1;
        @(negedge clk);
        tamper = 1'b0;
        chk(9, {30'h0, boot_ok, boot_abort}, 32'h1, "R9 tamper after trust aborts");
        chk(9, {31'h0, tgt_rst_n}, 32'h0, "R9 target back in reset");
        selftest(1'b1);
        spi_digest(32'hCAFEF00D, DB);
        chk(10, {30'h0, boot_ok, boot_abort}, 32'h1, "R10 abort is sticky");
        chk(10, {31'h0, tgt_rst_n}, 32'h0, "R10 target stays in reset");

        // Boot 2: failing self-test.
        power_up();
        chk(10, {31'h0, boot_abort}, 32'h0, "R10 reset clears abort");
        selftest(1'b0);
        chk(2, {31'h0, boot_abort}, 32'h1, "R2 self-test fail aborts");
        chk(2, {31'h0, tgt_rst_n}, 32'h0, "R2 target kept in reset");

        // Boot 3: wrong digest, fresh nonce.
        power_up();
        rng_value = 16'h5A3C;
        exp_nonce = 16'h5A3C;
        selftest(1'b1);
        chk(4, {16'h0, nonce_out}, 32'h00005A3C, "R4 new nonce per boot");
        spi_read(4, NADR, 2, 1'b1);                        // R4: nonce bytes served
        exp_digest = 32'h11223344;
        spi_digest(32'h11223345, DB);
        wait_clk(4);
        chk(7, {30'h0, boot_ok, boot_abort}, 32'h1, "R7 digest mismatch aborts");
        chk(7, {31'h0, tgt_rst_n}, 32'h0, "R7 target reset reasserted");

        // Boot 4: digest never completes.
        power_up();
        selftest(1'b1);
        spi_digest(32'h11223344, 2);
        chk(8, {31'h0, boot_abort}, 32'h0, "R8 no abort before timeout");
        chk(8, {31'h0, tgt_rst_n}, 32'h1, "R8 target running while waiting");
        wait_clk(400);
        chk(8, {31'h0, boot_abort}, 32'h1, "R8 timeout aborts");

        // Boot 5: tamper during self-test.
        power_up();
        @(negedge clk);
        tamper = 1'b1;
        @(negedge clk);
        tamper = 1'b0;
        chk(9, {31'h0, boot_abort}, 32'h1, "R9 tamper during self-test aborts");
        selftest(1'b1);
        chk(10, {31'h0, tgt_rst_n}, 32'h0, "R10 pass after abort ignored");

        wait_clk(4);
        chk(3, exp_q.size(), 32'h0, "R3 scoreboard drained");
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule